// File: doc/BRIEF.md
# Presence-Bit Remote Memory Request Engine

This block serves split-phase memory request messages that arrive from the network for words held in local memory. Every word has a presence state of EMPTY, FULL or PENDING. A message names an operation, a word address, a data value and a return continuation (instruction pointer and frame pointer). The block answers plain remote loads and remote stores. It also answers synchronizing loads, which wait for a word that has not been written yet. Each answer leaves as an outgoing message addressed to the requester's continuation.

A synchronizing load that finds its word unwritten is parked and causes no traffic. Its continuation goes into a fixed-size entry taken from a free list. The entries for one word form a chain, and the chain's head index is kept in the data word while the word is PENDING. The store that later fills the word walks the chain. It answers every parked reader with the new value, in the same form as a plain load answer, and returns each entry to the free list. The block handles one message at a time and holds off further messages with `in_ready` while it is busy.

Top module: `rme_presence_engine`

## Requirements
- R1: A load (`in_op` = 0) produces one output message to (`in_ret_ip`, `in_ret_fp`) carrying the addressed word's data. The message is valid on the second rising edge after the accepting edge.
- R2: A message is accepted on an edge where `in_valid` and `in_ready` are both high. `in_ready` is low on the cycle after acceptance and stays low until the message, including any chain walk, is finished.
- R3: A store (`in_op` = 1) to an EMPTY word writes the value and makes the word FULL. If `in_want_ack` is 1, an acknowledgement with value 0 goes to the return continuation on the second edge after acceptance. If `in_want_ack` is 0, no output message is produced.
- R4: A store to a FULL word raises `err_double_store` for one cycle on the second edge after acceptance. It produces no output message and leaves the word's data unchanged.
- R5: A synchronizing load (`in_op` = 2) to a FULL word answers exactly as a load does (R1).
- R6: A synchronizing load to an EMPTY or PENDING word produces no output message. It records the continuation against the word and leaves the word PENDING.
- R7: A store to a PENDING word writes the value and makes the word FULL. It then sends one message per parked reader, carrying the stored value, on consecutive edges, most recently parked reader first. The first of these comes one edge after the acknowledgement slot of R3, whether or not an acknowledgement is sent.
- R8: The pool holds `POOL` parked entries. When none is free, `in_ready` is low for a synchronizing load, and loads and stores are still accepted. Entries freed by a chain walk become usable again.
- R9: Operation code 3 is reserved. The message is consumed with no output, no error and no change to any word.
- R10: After reset, `in_ready` is 1, `out_valid` and `err_double_store` are 0, and every word is EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Block accepts the inbound message on this edge |
| in_op | input | 2 | Operation: 0 load, 1 store, 2 synchronizing load, 3 reserved |
| in_addr | input | ADDR_W | Word address |
| in_value | input | DATA_W | Store value |
| in_ret_ip | input | IP_W | Return continuation instruction pointer |
| in_ret_fp | input | FP_W | Return continuation frame pointer |
| in_want_ack | input | 1 | Store wants an acknowledgement |
| out_valid | output | 1 | Outbound message valid for this cycle |
| out_ip | output | IP_W | Destination instruction pointer |
| out_fp | output | FP_W | Destination frame pointer |
| out_value | output | DATA_W | Message value |
| err_double_store | output | 1 | Store hit an already FULL word |

## Verification
The first answer to a message, whether a load reply, a FULL synchronizing reply, an acknowledgement or an error pulse, is due on the second edge after the accepting edge. Chain-walk answers follow from the third edge onward, one per edge. The bench numbers the edges after each acceptance and records every output together with its edge number, over a window long enough for a full chain. It then compares both the contents and the edge number against the list its model predicts. A full pool and the error case are driven directly. Random traffic on a small address range produces repeated hits on the same words.

// File: rtl/rme_pkg.sv
package rme_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_SYNC  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PS_EMPTY = 2'd0,
    PS_FULL  = 2'd1,
    PS_PEND  = 2'd2
  } pres_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_DRAIN = 2'd2
  } fsm_e;
endpackage

// File: rtl/rme_word_store.sv
module rme_word_store
  import rme_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output pres_e             rd_ps,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ps_we,
  input  pres_e             ps_val
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  pres_e             ps  [DEPTH];

  // data array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // presence array is cleared on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ps[i] <= PS_EMPTY;
      rd_ps <= PS_EMPTY;
    end else begin
      if (ps_we) ps[wr_addr] <= ps_val;
      if (rd_en) rd_ps <= ps[rd_addr];
    end
  end
endmodule

// File: rtl/rme_free_list.sv
module rme_free_list #(
  parameter int POOL = 8,
  localparam int PIDX_W = (POOL > 1) ? $clog2(POOL) : 1,
  localparam int CNT_W  = $clog2(POOL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              release_en,
  input  logic [PIDX_W-1:0] rel_idx,
  output logic [PIDX_W-1:0] top_idx,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [PIDX_W-1:0] stk [POOL];
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < POOL; i++) stk[i] <= PIDX_W'(i);
      cnt <= CNT_W'(POOL);
    end else if (alloc) begin
      cnt <= cnt - 1'b1;
    end else if (release_en) begin
      stk[PIDX_W'(cnt)] <= rel_idx;
      cnt <= cnt + 1'b1;
    end
  end

  assign top_idx = stk[PIDX_W'(cnt - 1'b1)];
  assign empty   = (cnt == '0);
  assign count   = cnt;
endmodule

// File: rtl/rme_defer_pool.sv
module rme_defer_pool #(
  parameter int POOL = 8,
  parameter int IP_W = 12,
  parameter int FP_W = 16,
  localparam int PIDX_W = (POOL > 1) ? $clog2(POOL) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PIDX_W-1:0] widx,
  input  logic [IP_W-1:0]   w_ip,
  input  logic [FP_W-1:0]   w_fp,
  input  logic [PIDX_W-1:0] w_next,
  input  logic              w_last,
  input  logic [PIDX_W-1:0] ridx,
  output logic [IP_W-1:0]   r_ip,
  output logic [FP_W-1:0]   r_fp,
  output logic [PIDX_W-1:0] r_next,
  output logic              r_last
);
  logic [IP_W-1:0]   ip_a   [POOL];
  logic [FP_W-1:0]   fp_a   [POOL];
  logic [PIDX_W-1:0] next_a [POOL];
  logic              last_a [POOL];

  always_ff @(posedge clk) begin
    if (we) begin
      ip_a[widx]   <= w_ip;
      fp_a[widx]   <= w_fp;
      next_a[widx] <= w_next;
      last_a[widx] <= w_last;
    end
  end

  assign r_ip   = ip_a[ridx];
  assign r_fp   = fp_a[ridx];
  assign r_next = next_a[ridx];
  assign r_last = last_a[ridx];
endmodule

// File: rtl/rme_presence_engine.sv
module rme_presence_engine
  import rme_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IP_W   = 12,
  parameter int FP_W   = 16,
  parameter int POOL   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_value,
  input  logic [IP_W-1:0]   in_ret_ip,
  input  logic [FP_W-1:0]   in_ret_fp,
  input  logic              in_want_ack,
  output logic              out_valid,
  output logic [IP_W-1:0]   out_ip,
  output logic [FP_W-1:0]   out_fp,
  output logic [DATA_W-1:0] out_value,
  output logic              err_double_store
);
  localparam int PIDX_W = (POOL > 1) ? $clog2(POOL) : 1;
  localparam int CNT_W  = $clog2(POOL + 1);

  // request latched at acceptance
  fsm_e              fsm, fsm_nxt;
  op_e               r_op;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_value;
  logic [IP_W-1:0]   r_ip;
  logic [FP_W-1:0]   r_fp;
  logic              r_ack;
  logic [PIDX_W-1:0] walk_ptr, walk_ptr_nxt;

  // word store
  logic [DATA_W-1:0] ws_data;
  pres_e             ws_ps;
  logic              ws_wr, ws_ps_we;
  logic [DATA_W-1:0] ws_wdata;
  pres_e             ws_ps_val;

  // free list and pool
  logic              fl_alloc, fl_release, fl_empty;
  logic [PIDX_W-1:0] fl_top;
  logic [CNT_W-1:0]  fl_count;
  logic              pl_we;
  logic [IP_W-1:0]   pl_ip;
  logic [FP_W-1:0]   pl_fp;
  logic [PIDX_W-1:0] pl_next;
  logic              pl_last;

  // response decided this cycle
  logic              emit, err_now;
  logic [IP_W-1:0]   e_ip;
  logic [FP_W-1:0]   e_fp;
  logic [DATA_W-1:0] e_val;

  logic accept;
  logic [PIDX_W-1:0] head;

  assign in_ready = (fsm == ST_IDLE) && !((op_e'(in_op) == OP_SYNC) && fl_empty);
  assign accept   = in_valid && in_ready;
  assign head     = ws_data[PIDX_W-1:0];

  rme_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) word_i (
    .clk(clk), .rst(rst),
    .rd_en(accept), .rd_addr(in_addr), .rd_data(ws_data), .rd_ps(ws_ps),
    .wr_en(ws_wr), .wr_addr(r_addr), .wr_data(ws_wdata),
    .ps_we(ws_ps_we), .ps_val(ws_ps_val)
  );

  rme_free_list #(.POOL(POOL)) free_i (
    .clk(clk), .rst(rst),
    .alloc(fl_alloc), .release_en(fl_release), .rel_idx(walk_ptr),
    .top_idx(fl_top), .empty(fl_empty), .count(fl_count)
  );

  rme_defer_pool #(.POOL(POOL), .IP_W(IP_W), .FP_W(FP_W)) pool_i (
    .clk(clk),
    .we(pl_we), .widx(fl_top), .w_ip(r_ip), .w_fp(r_fp),
    .w_next(head), .w_last(ws_ps != PS_PEND),
    .ridx(walk_ptr), .r_ip(pl_ip), .r_fp(pl_fp),
    .r_next(pl_next), .r_last(pl_last)
  );

  always_comb begin
    fsm_nxt      = fsm;
    walk_ptr_nxt = walk_ptr;
    emit         = 1'b0;
    err_now      = 1'b0;
    e_ip         = r_ip;
    e_fp         = r_fp;
    e_val        = ws_data;
    ws_wr        = 1'b0;
    ws_wdata     = r_value;
    ws_ps_we     = 1'b0;
    ws_ps_val    = PS_FULL;
    fl_alloc     = 1'b0;
    fl_release   = 1'b0;
    pl_we        = 1'b0;
    unique case (fsm)
      ST_IDLE: if (accept) fsm_nxt = ST_EXEC;
      ST_EXEC: begin
        fsm_nxt = ST_IDLE;
        unique case (r_op)
          OP_LOAD: emit = 1'b1;
          OP_STORE: begin
            if (ws_ps == PS_FULL) begin
              err_now = 1'b1;
            end else begin
              ws_wr    = 1'b1;
              ws_ps_we = 1'b1;
              emit     = r_ack;
              e_val    = '0;
              if (ws_ps == PS_PEND) begin
                fsm_nxt      = ST_DRAIN;
                walk_ptr_nxt = head;
              end
            end
          end
          OP_SYNC: begin
            if (ws_ps == PS_FULL) begin
              emit = 1'b1;
            end else begin
              fl_alloc  = 1'b1;
              pl_we     = 1'b1;
              ws_wr     = 1'b1;
              ws_wdata  = DATA_W'(fl_top);
              ws_ps_we  = 1'b1;
              ws_ps_val = PS_PEND;
            end
          end
          default: ;
        endcase
      end
      ST_DRAIN: begin
        emit         = 1'b1;
        e_ip         = pl_ip;
        e_fp         = pl_fp;
        e_val        = r_value;
        fl_release   = 1'b1;
        walk_ptr_nxt = pl_next;
        if (pl_last) fsm_nxt = ST_IDLE;
      end
      default: fsm_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm              <= ST_IDLE;
      walk_ptr         <= '0;
      r_op             <= OP_RSVD;
      r_addr           <= '0;
      r_value          <= '0;
      r_ip             <= '0;
      r_fp             <= '0;
      r_ack            <= 1'b0;
      out_valid        <= 1'b0;
      out_ip           <= '0;
      out_fp           <= '0;
      out_value        <= '0;
      err_double_store <= 1'b0;
    end else begin
      fsm      <= fsm_nxt;
      walk_ptr <= walk_ptr_nxt;
      if (accept) begin
        r_op    <= op_e'(in_op);
        r_addr  <= in_addr;
        r_value <= in_value;
        r_ip    <= in_ret_ip;
        r_fp    <= in_ret_fp;
        r_ack   <= in_want_ack;
      end
      out_valid        <= emit;
      err_double_store <= err_now;
      if (emit) begin
        out_ip    <= e_ip;
        out_fp    <= e_fp;
        out_value <= e_val;
      end
    end
  end
endmodule

// File: rtl/rme_presence_engine_chk.sv
module rme_presence_engine_chk #(
  parameter int POOL  = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic             out_valid,
  input logic             err_double_store,
  input logic             fl_empty,
  input logic [CNT_W-1:0] fl_count
);
  // R8: a synchronizing load is held off while no entry is free
  a_r8_stall_when_pool_empty: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'd2 && fl_empty) |-> !in_ready);

  // R8: the free count never exceeds the pool size
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    fl_count <= CNT_W'(POOL));

  // R2: busy on the cycle after acceptance
  a_r2_single_issue: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R1: a load is answered two edges after acceptance
  a_r1_load_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 2'd0) |-> ##2 out_valid);

  // R4: an error pulse comes with no outbound message
  a_r4_error_silent: assert property (@(posedge clk) disable iff (rst)
    err_double_store |-> !out_valid);

  // R9: a reserved operation leaves both outputs quiet
  a_r9_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 2'd3) |-> ##2 (!out_valid && !err_double_store));
endmodule

bind rme_presence_engine rme_presence_engine_chk #(.POOL(POOL), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .out_valid(out_valid), .err_double_store(err_double_store),
  .fl_empty(fl_empty), .fl_count(fl_count)
);

// File: tb/rme_presence_engine_tb_top.sv
`timescale 1ns/1ps
module rme_presence_engine_tb_top;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int IP_W   = 12;
  localparam int FP_W   = 16;
  localparam int POOL   = 8;
  localparam int NW     = 1 << ADDR_W;
  localparam int WIN    = POOL + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'd0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_value = '0;
  logic [IP_W-1:0] in_ret_ip = '0;
  logic [FP_W-1:0] in_ret_fp = '0;
  logic in_want_ack = 1'b0;
  logic out_valid;
  logic [IP_W-1:0] out_ip;
  logic [FP_W-1:0] out_fp;
  logic [DATA_W-1:0] out_value;
  logic err_double_store;

  always #2.5 clk = ~clk;

  rme_presence_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IP_W(IP_W),
    .FP_W(FP_W), .POOL(POOL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_value(in_value),
    .in_ret_ip(in_ret_ip), .in_ret_fp(in_ret_fp), .in_want_ack(in_want_ack),
    .out_valid(out_valid), .out_ip(out_ip), .out_fp(out_fp),
    .out_value(out_value), .err_double_store(err_double_store)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int k;
    logic [IP_W-1:0] ip;
    logic [FP_W-1:0] fp;
    logic [DATA_W-1:0] v;
  } ev_t;
  typedef struct {
    logic [IP_W-1:0] ip;
    logic [FP_W-1:0] fp;
  } cont_t;

  // reference model
  logic [DATA_W-1:0] data_m [NW];
  int                st_m   [NW];   // 0 empty, 1 full, 2 pending
  cont_t             dq     [NW][$];
  int                free_m;

  ev_t obs [$];
  ev_t expq [$];
  int  err_k;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one message, wait for acceptance, record the window after it
  task automatic send(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] v, input logic [IP_W-1:0] ip,
                      input logic [FP_W-1:0] fp, input logic ack);
    @(negedge clk);
    in_op = op; in_addr = a; in_value = v; in_ret_ip = ip;
    in_ret_fp = fp; in_want_ack = ack; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    obs.delete();
    err_k = 0;
    chk(in_ready == 1'b0, "R2", "busy after accept", 64'(in_ready), 64'd0);
    for (int k = 1; k <= WIN; k++) begin
      if (k > 1) @(negedge clk);
      if (out_valid) obs.push_back('{k, out_ip, out_fp, out_value});
      if (err_double_store) err_k = k;
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] v, input logic [IP_W-1:0] ip,
                       input logic [FP_W-1:0] fp, input logic ack, input string req);
    int exp_err;
    expq.delete();
    exp_err = 0;
    case (op)
      2'd0: expq.push_back('{2, ip, fp, data_m[a]});
      2'd1: begin
        if (st_m[a] == 1) exp_err = 2;
        else begin
          if (ack) expq.push_back('{2, ip, fp, '0});
          for (int j = 0; j < dq[a].size(); j++)
            expq.push_back('{3 + j, dq[a][j].ip, dq[a][j].fp, v});
          free_m += dq[a].size();
          dq[a].delete();
          data_m[a] = v;
          st_m[a] = 1;
        end
      end
      2'd2: begin
        if (st_m[a] == 1) expq.push_back('{2, ip, fp, data_m[a]});
        else begin
          dq[a].push_front('{ip, fp});
          st_m[a] = 2;
          free_m--;
        end
      end
      default: ;
    endcase
    send(op, a, v, ip, fp, ack);
    chk(obs.size() == expq.size(), req, "message count",
        64'(obs.size()), 64'(expq.size()));
    for (int i = 0; i < obs.size() && i < expq.size(); i++) begin
      chk({obs[i].ip, obs[i].fp, obs[i].v} == {expq[i].ip, expq[i].fp, expq[i].v},
          req, "message content",
          64'({obs[i].ip, obs[i].fp, obs[i].v}), 64'({expq[i].ip, expq[i].fp, expq[i].v}));
      chk(obs[i].k == expq[i].k, req, "message edge", 64'(obs[i].k), 64'(expq[i].k));
    end
    chk(err_k == exp_err, (exp_err != 0) ? "R4" : req, "error pulse edge",
        64'(err_k), 64'(exp_err));
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) begin
      st_m[i] = 0;
      data_m[i] = '0;
    end
    free_m = POOL;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    chk(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(err_double_store == 1'b0, "R10", "error after reset", 64'(err_double_store), 64'd0);

    // R10 R6: word 0 starts EMPTY, so a synchronizing load parks
    apply(2'd2, 6'd0, '0, 12'h101, 16'hA001, 1'b0, "R6");
    // R7 store with ack to a pending word: ack then the parked reader
    apply(2'd1, 6'd0, 16'h1234, 12'h102, 16'hA002, 1'b1, "R7");
    // R1 load of the filled word
    apply(2'd0, 6'd0, '0, 12'h103, 16'hA003, 1'b0, "R1");
    // R5 synchronizing load of a FULL word
    apply(2'd2, 6'd0, '0, 12'h104, 16'hA004, 1'b0, "R5");
    // R4 second store to a FULL word, then the word still holds 1234
    apply(2'd1, 6'd0, 16'hDEAD, 12'h105, 16'hA005, 1'b1, "R4");
    apply(2'd0, 6'd0, '0, 12'h106, 16'hA006, 1'b0, "R4");
    // R3 store with and without ack to EMPTY words
    apply(2'd1, 6'd1, 16'h0055, 12'h107, 16'hA007, 1'b1, "R3");
    apply(2'd1, 6'd2, 16'h0066, 12'h108, 16'hA008, 1'b0, "R3");
    // R9 reserved op on a FULL word; a load shows it untouched
    apply(2'd3, 6'd2, 16'hFFFF, 12'h109, 16'hA009, 1'b1, "R9");
    apply(2'd0, 6'd2, '0, 12'h10A, 16'hA00A, 1'b0, "R9");
    // R9 reserved op on an EMPTY word leaves it EMPTY: a store then succeeds
    apply(2'd3, 6'd3, 16'hFFFF, 12'h10B, 16'hA00B, 1'b0, "R9");
    apply(2'd1, 6'd3, 16'h0077, 12'h10C, 16'hA00C, 1'b1, "R9");

    // R8: fill the whole pool on one word
    for (int i = 0; i < POOL; i++)
      apply(2'd2, 6'd10, '0, 12'(12'h200 + i), 16'(16'hB000 + i), 1'b0, "R6");
    @(negedge clk);
    in_op = 2'd2; in_addr = 6'd11; in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(in_ready == 1'b0, "R8", "sync held with pool empty", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    // R8: other operations still go through
    apply(2'd0, 6'd1, '0, 12'h300, 16'hC000, 1'b0, "R8");
    // R7: walk of a full chain, newest first, no ack
    apply(2'd1, 6'd10, 16'h4242, 12'h301, 16'hC001, 1'b0, "R7");
    // R8: freed entries are usable again
    apply(2'd2, 6'd11, '0, 12'h302, 16'hC002, 1'b0, "R8");
    apply(2'd1, 6'd11, 16'h0909, 12'h303, 16'hC003, 1'b1, "R7");

    // random traffic on a small address range
    for (int n = 0; n < 300; n++) begin
      int r;
      logic [1:0] op;
      logic [ADDR_W-1:0] a;
      r = int'($urandom % 10);
      a = ADDR_W'(32 + ($urandom % 8));
      if (r < 3) op = 2'd0;
      else if (r < 6) op = 2'd1;
      else if (r < 9) op = 2'd2;
      else op = 2'd3;
      if (op == 2'd0 && st_m[a] != 1) op = 2'd2;
      if (op == 2'd2 && st_m[a] != 1 && free_m == 0) op = 2'd1;
      apply(op, a, DATA_W'($urandom), IP_W'($urandom), FP_W'($urandom),
            1'($urandom), (op == 2'd0) ? "R1" : (op == 2'd1) ? "R3" :
            (op == 2'd2) ? "R5" : "R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule